// File: doc/BRIEF.md
# I/O-Port Arithmetic Unit

This block lends add, subtract and bitwise logic to a processor core that has no adder of its own. It is not part of the core's datapath. It sits on the core's I/O bus as a peripheral, and software reaches it only through I/O instructions. It claims four consecutive device-select codes, starting at a base code set by a parameter. Two of these codes are write-only operand registers. The third holds a control byte that carries the operation code, the carry-in and a logic/arithmetic mode bit. The fourth returns the result.

Software runs one calculation in four steps: write operand A, write operand B, write the control byte, then read the result port. The result is pure combinational logic on the three registers, so it can be read in the cycle right after the last write. A read at the control port's code returns the carry-out of the last arithmetic operation, which supports multi-precision and scaling routines. Select code zero means "no device" and never decodes.

Top module: `io_alu_port`

## Requirements
- R1: After reset, operand A, operand B and the control byte are all zero, so the result read returns 0x00 and the status read returns 0x00.
- R2: A write takes effect on the rising clock edge where `io_wr` is high and `io_sel` matches the port. BASE_SEL+0 loads operand A, BASE_SEL+1 loads operand B and BASE_SEL+2 loads the control byte.
- R3: A write with `io_wr` low, or a write to a select code outside the four ports, leaves every register unchanged.
- R4: Select code 0 and every code outside BASE_SEL+2 and BASE_SEL+3 give `io_rd_hit` = 0 and `io_rdata` = 0x00 on a read. The write-only codes BASE_SEL+0 and BASE_SEL+1 also read as 0x00 with no hit.
- R5: Control byte layout: bits [3:0] are the operation code, bit 4 is the carry-in, and bit 5 is the mode (0 = arithmetic, 1 = logic). Bits 7:6 are ignored.
- R6: Arithmetic operations:
  - code 0 gives A+B+cin.
  - code 1 gives A+~B+cin, which is A-B when cin=1.
  - every other code gives A+cin.
  - The carry-out is bit 8 of the 9-bit sum.
- R7: Logic operations:
  - code 0 gives A&B, code 1 gives A|B and code 2 gives A^B.
  - code 3 gives A, code 4 gives ~A and code 5 gives B.
  - other codes give 0x00.
  - The carry-out is always 0 in logic mode.
- R8: A read at BASE_SEL+3 returns the result, and a read at BASE_SEL+2 returns the carry-out in bit 0 with bits 7:1 zero. Both are combinational, in the same cycle as `io_rd`.
- R9: Reads have no side effects: repeated reads return the same value. `io_rd_hit` is high only while `io_rd` is high at a readable port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel | input | 4 | Device select code |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, zero when no readable port is hit |
| io_rd_hit | output | 1 | High when a read addresses the result or status port |

## Verification
The main function is driven with a table of operand and control patterns, for both modes and across every operation code.

- Carry-producing additions and no-carry additions show that bit 8 of the sum is captured.
- Subtractions with a positive result and with a negative result show the difference between borrow and no-borrow.
- The A+cin case with A=0xFF checks the wrap to zero.
- In logic mode, operands with mixed bit patterns (0xCC and 0xAA) tell AND, OR and XOR apart from each other and from the pass and complement operations.
- A carry-in set in logic mode shows that it leaks into neither the result nor the carry flag.
- Control bytes with bits 7:6 set show that those bits are ignored.

// File: rtl/io_alu_pkg.sv
package io_alu_pkg;
  localparam int CTL_OP_LSB = 0;
  localparam int CTL_OP_W   = 4;
  localparam int CTL_CIN    = 4;
  localparam int CTL_MODE   = 5;
  localparam int NUM_PORTS  = 4;

  typedef enum logic [1:0] {
    PORT_OPA = 2'd0,
    PORT_OPB = 2'd1,
    PORT_CTL = 2'd2,
    PORT_RES = 2'd3
  } port_e;

  typedef enum logic [3:0] {
    AOP_ADD = 4'd0,
    AOP_SUB = 4'd1
  } arith_op_e;

  typedef enum logic [3:0] {
    LOP_AND  = 4'd0,
    LOP_OR   = 4'd1,
    LOP_XOR  = 4'd2,
    LOP_PASA = 4'd3,
    LOP_NOTA = 4'd4,
    LOP_PASB = 4'd5
  } logic_op_e;
endpackage

// File: rtl/io_alu_decode.sv
module io_alu_decode #(
  parameter int SEL_W    = 4,
  parameter int BASE_SEL = 4
) (
  input  logic [SEL_W-1:0] io_sel,
  output logic [io_alu_pkg::NUM_PORTS-1:0] port_hit
);
  localparam int NP = io_alu_pkg::NUM_PORTS;

  for (genvar i = 0; i < NP; i++) begin : g_hit
    localparam logic [SEL_W-1:0] CODE = SEL_W'(BASE_SEL + i);
    // select code zero is the idle bus and never decodes
    assign port_hit[i] = (io_sel == CODE) && (io_sel != '0);
  end
endmodule

// File: rtl/io_alu_regs.sv
module io_alu_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_a,
  input  logic              ld_b,
  input  logic              ld_ctl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] a_q,
  output logic [DATA_W-1:0] b_q,
  output logic [DATA_W-1:0] ctl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      ctl_q <= '0;
    end else begin
      if (ld_a)   a_q   <= wdata;
      if (ld_b)   b_q   <= wdata;
      if (ld_ctl) ctl_q <= wdata;
    end
  end
endmodule

// File: rtl/io_alu_core.sv
module io_alu_core #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] ctl,
  output logic [DATA_W-1:0] result,
  output logic              cout
);
  import io_alu_pkg::*;

  localparam int SUM_W = DATA_W + 1;

  function automatic logic [SUM_W-1:0] arith_eval(
    input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y,
    input logic [3:0] op, input logic ci);
    logic [SUM_W-1:0] addend;
    case (op)
      AOP_ADD: addend = {1'b0, y};
      AOP_SUB: addend = {1'b0, ~y};
      default: addend = '0;
    endcase
    return {1'b0, x} + addend + SUM_W'(ci);
  endfunction

  function automatic logic [DATA_W-1:0] logic_eval(
    input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y,
    input logic [3:0] op);
    case (op)
      LOP_AND:  return x & y;
      LOP_OR:   return x | y;
      LOP_XOR:  return x ^ y;
      LOP_PASA: return x;
      LOP_NOTA: return ~x;
      LOP_PASB: return y;
      default:  return '0;
    endcase
  endfunction

  logic [3:0]       op_code;
  logic             cin;
  logic             logic_mode;
  logic [SUM_W-1:0] sum;

  assign op_code    = ctl[CTL_OP_LSB +: CTL_OP_W];
  assign cin        = ctl[CTL_CIN];
  assign logic_mode = ctl[CTL_MODE];
  assign sum        = arith_eval(a, b, op_code, cin);

  always_comb begin
    if (logic_mode) begin
      result = logic_eval(a, b, op_code);
      cout   = 1'b0;
    end else begin
      result = sum[DATA_W-1:0];
      cout   = sum[DATA_W];
    end
  end
endmodule

// File: rtl/io_alu_port.sv
module io_alu_port #(
  parameter int DATA_W   = 8,
  parameter int SEL_W    = 4,
  parameter int BASE_SEL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  io_sel,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_rd_hit
);
  import io_alu_pkg::*;

  logic [NUM_PORTS-1:0] port_hit;
  logic                 wr_a_evt, wr_b_evt, wr_ctl_evt;
  logic                 rd_res_evt, rd_stat_evt;
  logic [DATA_W-1:0]    a_q, b_q, ctl_q;
  logic [DATA_W-1:0]    alu_res;
  logic                 alu_cout;

  io_alu_decode #(.SEL_W(SEL_W), .BASE_SEL(BASE_SEL)) u_dec (
    .io_sel   (io_sel),
    .port_hit (port_hit)
  );

  assign wr_a_evt    = io_wr && port_hit[PORT_OPA];
  assign wr_b_evt    = io_wr && port_hit[PORT_OPB];
  assign wr_ctl_evt  = io_wr && port_hit[PORT_CTL];
  assign rd_stat_evt = io_rd && port_hit[PORT_CTL];
  assign rd_res_evt  = io_rd && port_hit[PORT_RES];

  io_alu_regs #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_a   (wr_a_evt),
    .ld_b   (wr_b_evt),
    .ld_ctl (wr_ctl_evt),
    .wdata  (io_wdata),
    .a_q    (a_q),
    .b_q    (b_q),
    .ctl_q  (ctl_q)
  );

  io_alu_core #(.DATA_W(DATA_W)) u_core (
    .a      (a_q),
    .b      (b_q),
    .ctl    (ctl_q),
    .result (alu_res),
    .cout   (alu_cout)
  );

  always_comb begin
    if (rd_res_evt)       io_rdata = alu_res;
    else if (rd_stat_evt) io_rdata = DATA_W'(alu_cout);
    else                  io_rdata = '0;
  end

  assign io_rd_hit = rd_res_evt || rd_stat_evt;
endmodule

// File: rtl/io_alu_port_chk.sv
module io_alu_port_chk #(
  parameter int DATA_W   = 8,
  parameter int SEL_W    = 4,
  parameter int BASE_SEL = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  io_sel,
  input logic              io_rd,
  input logic [DATA_W-1:0] io_wdata,
  input logic [DATA_W-1:0] io_rdata,
  input logic              io_rd_hit,
  input logic              wr_a_evt,
  input logic              wr_b_evt,
  input logic              wr_ctl_evt,
  input logic [DATA_W-1:0] a_q,
  input logic [DATA_W-1:0] b_q,
  input logic [DATA_W-1:0] ctl_q,
  input logic              alu_cout
);
  localparam logic [SEL_W-1:0] STAT_CODE = SEL_W'(BASE_SEL + 2);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (a_q == '0) && (b_q == '0) && (ctl_q == '0));

  // R2
  load_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a_evt |=> a_q == $past(io_wdata));

  // R2
  load_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl_evt |=> ctl_q == $past(io_wdata));

  // R3
  hold_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_a_evt && !wr_b_evt && !wr_ctl_evt) |=>
      ($stable(a_q) && $stable(b_q) && $stable(ctl_q)));

  // R7
  logic_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[5] |-> !alu_cout);

  // R8
  status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_sel == STAT_CODE) |-> io_rdata[DATA_W-1:1] == '0);

  // R9
  hit_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd_hit |-> io_rd);

  // R4
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd_hit |-> io_rdata == '0);
endmodule

bind io_alu_port io_alu_port_chk #(
  .DATA_W(DATA_W), .SEL_W(SEL_W), .BASE_SEL(BASE_SEL)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_sel     (io_sel),
  .io_rd      (io_rd),
  .io_wdata   (io_wdata),
  .io_rdata   (io_rdata),
  .io_rd_hit  (io_rd_hit),
  .wr_a_evt   (wr_a_evt),
  .wr_b_evt   (wr_b_evt),
  .wr_ctl_evt (wr_ctl_evt),
  .a_q        (a_q),
  .b_q        (b_q),
  .ctl_q      (ctl_q),
  .alu_cout   (alu_cout)
);

// File: tb/tb_io_alu_port.sv
`timescale 1ns/1ps
module tb_io_alu_port;
  localparam int BASE = 4;
  localparam logic [3:0] S_A = 4'(BASE), S_B = 4'(BASE+1),
                         S_C = 4'(BASE+2), S_R = 4'(BASE+3);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] io_sel = '0;
  logic       io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic       io_rd_hit;
  int checks = 0, errors = 0;

  io_alu_port #(.DATA_W(8), .SEL_W(4), .BASE_SEL(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_rd_hit(io_rd_hit)
  );

  always #2 clk = ~clk;

  // {A, B, CTL, result, carry}
  localparam int NV = 15;
  localparam logic [32:0] VEC [NV] = '{
    {8'h35, 8'h4A, 8'h00, 8'h7F, 1'b0},  // R6 add
    {8'hF0, 8'h20, 8'h10, 8'h11, 1'b1},  // R6 add carry-in, carry-out
    {8'h50, 8'h20, 8'h11, 8'h30, 1'b1},  // R6 sub no borrow
    {8'h10, 8'h20, 8'h11, 8'hF0, 1'b0},  // R6 sub borrow
    {8'hFF, 8'h00, 8'h12, 8'h00, 1'b1},  // R6 A+cin wrap
    {8'hCC, 8'hAA, 8'h20, 8'h88, 1'b0},  // R7 and
    {8'hCC, 8'hAA, 8'h21, 8'hEE, 1'b0},  // R7 or
    {8'hCC, 8'hAA, 8'h22, 8'h66, 1'b0},  // R7 xor
    {8'hCC, 8'hAA, 8'h23, 8'hCC, 1'b0},  // R7 pass A
    {8'hCC, 8'hAA, 8'h24, 8'h33, 1'b0},  // R7 not A
    {8'hCC, 8'hAA, 8'h25, 8'hAA, 1'b0},  // R7 pass B
    {8'hCC, 8'hAA, 8'h2F, 8'h00, 1'b0},  // R7 unused code
    {8'h01, 8'h02, 8'hC0, 8'h03, 1'b0},  // R5 bits 7:6 ignored
    {8'hFF, 8'h0F, 8'h30, 8'h0F, 1'b0},  // R5 cin no effect in logic
    {8'h7F, 8'h55, 8'h09, 8'h7F, 1'b0}   // R6 other arith code
  };

  task automatic check(input string req, input logic [8:0] act,
                       input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_port(input logic [3:0] s, input logic [7:0] d,
                         input logic strobe);
    @(negedge clk);
    io_sel = s; io_wdata = d; io_wr = strobe;
    @(negedge clk);
    io_wr = 1'b0; io_sel = '0;
  endtask

  task automatic rd_port(input logic [3:0] s, output logic [7:0] d,
                         output logic hit);
    @(negedge clk);
    io_sel = s; io_rd = 1'b1;
    #1;
    d = io_rdata; hit = io_rd_hit;
    @(negedge clk);
    io_rd = 1'b0; io_sel = '0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    logic h, h2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    rd_port(S_R, d, h);  check("R1 result", {h, d}, {1'b1, 8'h00});
    rd_port(S_C, d, h);  check("R1 status", {h, d}, {1'b1, 8'h00});

    for (int i = 0; i < NV; i++) begin
      wr_port(S_A, VEC[i][32:25], 1'b1);  // R2
      wr_port(S_B, VEC[i][24:17], 1'b1);
      wr_port(S_C, VEC[i][16:9], 1'b1);
      rd_port(S_R, d, h);
      check($sformatf("R8 R6/R7 result vec%0d", i), {h, d}, {1'b1, VEC[i][8:1]});
      rd_port(S_C, d, h);
      check($sformatf("R8 status vec%0d", i), {h, d}, {1'b1, 7'h0, VEC[i][0]});
    end

    // setup: A=0x10 B=0x01 add -> 0x11
    wr_port(S_A, 8'h10, 1'b1);
    wr_port(S_B, 8'h01, 1'b1);
    wr_port(S_C, 8'h00, 1'b1);
    // R3 strobe low
    wr_port(S_A, 8'h80, 1'b0);
    rd_port(S_R, d, h);  check("R3 no strobe", {1'b0, d}, 9'h011);
    // R3 foreign select codes
    wr_port(4'h0, 8'h80, 1'b1);
    wr_port(4'h9, 8'h80, 1'b1);
    wr_port(4'(BASE-1), 8'h80, 1'b1);
    rd_port(S_R, d, h);  check("R3 other select", {1'b0, d}, 9'h011);
    // R4 unreadable codes
    rd_port(4'h0, d, h);  check("R4 sel0", {h, d}, 9'h000);
    rd_port(S_A, d, h);   check("R4 opA read", {h, d}, 9'h000);
    rd_port(S_B, d, h);   check("R4 opB read", {h, d}, 9'h000);
    rd_port(4'hF, d, h);  check("R4 selF", {h, d}, 9'h000);
    // R9 no rd -> no hit
    @(negedge clk); io_sel = S_R; #1;
    check("R9 hit without rd", {io_rd_hit, io_rdata}, 9'h000);
    // R9 repeated reads stable
    rd_port(S_R, d, h); rd_port(S_R, d2, h2);
    check("R9 repeat read", {h2, d2}, {h, d});
    // R2 operand B reload changes result
    wr_port(S_B, 8'h0F, 1'b1);
    rd_port(S_R, d, h);  check("R2 opB reload", {h, d}, 9'h11F);
    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_port(S_R, d, h);  check("R1 reset again", {h, d}, 9'h100);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule